// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Unit

This block keeps the status register of a serial memory and rules on every write that the command decoder asks for. It holds a write-enable latch, a busy flag, a two-bit block-protect field and a protect-enable bit. A command decoder feeds it one-cycle strobes: set latch, clear latch, array write request (with target address), status write request (with new status byte) and write-cycle end. The array controller acts on the grant or deny pulse that comes back.

The status byte can be read at any time from `statusOut`. While an internal write runs, it reads all ones. Block protection splits the address space into four quarters. The two protect bits choose whether nothing is guarded, the top quarter is guarded, the top half is guarded or the whole array is guarded. Guarded addresses stay readable; only writes to them are refused. With protect enable set, a low level on the active-low write-protect pin also refuses status writes. The protect bits reset to a parameter value that stands in for retained nonvolatile state.

Top module: `srp_top`

## Requirements
- R1: After reset the latch and busy flag are 0 and the protect enable and block-protect bits take the value of `INIT_PROT` (`{wpen,bp1,bp0}`). With the default, `statusOut` is 0x00.
- R2: When idle, `statusOut` is `{wpen,3'b000,bp1,bp0,wel,busy}`: bit 7 is protect enable, bits 3:2 are the block-protect field, bit 1 is the latch and bits 6:4 read 0. Only a granted status write changes bits 7, 3 and 2, and it copies them from the same positions of `statusWrData`.
- R3: `wrenCmd` sets the latch. `wrdiCmd` clears it, and `wrdiCmd` wins when both are asserted. The latch also clears when a write cycle ends.
- R4: Any array or status write request is denied while the latch is clear.
- R5: A granted request sets busy on the same edge that raises `wrGrant`. While busy, `statusOut` reads 0xFF. `cycleEnd` clears busy.
- R6: `wrGrant` and `wrDeny` are one-cycle pulses, valid in the cycle after the request edge. A denied request leaves busy clear and leaves the status unchanged.
- R7: While busy, every write request is denied and `wrenCmd` and `wrdiCmd` are ignored.
- R8: The block-protect field guards array writes by the two top address bits: 00 guards nothing, 01 guards quarter 3 (0x1800–0x1FFF at 13 bits), 10 guards quarters 2 and 3 (0x1000–0x1FFF), and 11 guards all addresses. A write to a guarded address is denied.
- R9: With protect enable at 1 and `writeProtectN` low, status write requests are denied. Array write requests do not depend on the pin.
- R10: An array request and a status request in the same cycle are both denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrenCmd | input | 1 | Set write-enable latch strobe |
| wrdiCmd | input | 1 | Clear write-enable latch strobe |
| arrayWrReq | input | 1 | Array write request strobe |
| wrAddr | input | ADDR_W | Target address of array write |
| statusWrReq | input | 1 | Status write request strobe |
| statusWrData | input | 8 | New status byte |
| cycleEnd | input | 1 | Internal write cycle finished |
| writeProtectN | input | 1 | Write-protect pin, active low |
| statusOut | output | 8 | Status byte for read-out |
| wrGrant | output | 1 | Write allowed pulse |
| wrDeny | output | 1 | Write refused pulse |

## Verification
Array writes are tried at the two addresses on each side of every quarter boundary under each protect setting. This separates a correct map from one that is shifted or off by one quarter. Status writes are tried with the pin high and low, and with protect enable set and clear, so that pin gating is told apart from latch gating. Requests, latch commands and a second request are sent while a cycle runs and just after it ends. These show whether the busy gate, the 0xFF read-back and the latch auto-clear each act on the right edge.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setBusy;
    logic clrBusy;
    logic loadProt;
  } strobe_t;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } prot_t;
endpackage

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [2:0] INIT_PROT = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic              welQ,
  output logic              busyQ,
  output logic              wpenQ,
  output logic              addrProtected,
  output logic [7:0]        statusOut
);
  localparam int QHI = ADDR_W - 1;
  localparam int QLO = ADDR_W - 2;

  prot_t      protQ;
  logic [1:0] quarter;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      welQ  <= 1'b0;
      busyQ <= 1'b0;
      protQ <= prot_t'(INIT_PROT);
    end else begin
      if (stb.clrWel)       welQ <= 1'b0;
      else if (stb.setWel)  welQ <= 1'b1;
      if (stb.setBusy)      busyQ <= 1'b1;
      else if (stb.clrBusy) busyQ <= 1'b0;
      if (stb.loadProt) begin
        protQ.wpen <= wrData[7];
        protQ.bp   <= wrData[3:2];
      end
    end
  end

  assign quarter = addr[QHI:QLO];

  always_comb begin
    unique case (protQ.bp)
      2'b00:   addrProtected = 1'b0;
      2'b01:   addrProtected = (quarter == 2'b11);
      2'b10:   addrProtected = quarter[1];
      default: addrProtected = 1'b1;
    endcase
  end

  assign wpenQ     = protQ.wpen;
  assign statusOut = busyQ ? 8'hFF : {protQ.wpen, 3'b000, protQ.bp, welQ, 1'b0};

  // R5: busy reads back as all ones
  a_r5_busy_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ |-> (statusOut == 8'hFF));
  // R3: latch is clear once a cycle ends
  a_r3_end_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyQ) |-> !welQ);
  // R2: protect bits never move outside a write cycle
  a_r2_prot_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busyQ |-> $stable(protQ));
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wrenCmd,
  input  logic    wrdiCmd,
  input  logic    arrayWrReq,
  input  logic    statusWrReq,
  input  logic    cycleEnd,
  input  logic    writeProtectN,
  input  logic    welIn,
  input  logic    busyIn,
  input  logic    wpenIn,
  input  logic    addrProtected,
  output strobe_t stb,
  output logic    wrGrant,
  output logic    wrDeny
);
  logic anyReq, bothReq, okArray, okStatus, statusLocked;

  assign anyReq       = arrayWrReq | statusWrReq;
  assign bothReq      = arrayWrReq & statusWrReq;
  assign statusLocked = wpenIn & !writeProtectN;
  assign okArray  = arrayWrReq  & !bothReq & welIn & !busyIn & !addrProtected;
  assign okStatus = statusWrReq & !bothReq & welIn & !busyIn & !statusLocked;

  always_comb begin
    stb          = '0;
    stb.clrBusy  = cycleEnd & busyIn;
    stb.clrWel   = stb.clrBusy | (wrdiCmd & !busyIn);
    stb.setWel   = wrenCmd & !busyIn;
    stb.setBusy  = okArray | okStatus;
    stb.loadProt = okStatus;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrGrant <= 1'b0;
      wrDeny  <= 1'b0;
    end else begin
      wrGrant <= okArray | okStatus;
      wrDeny  <= anyReq & !(okArray | okStatus);
    end
  end

  // R5: a grant comes with busy raised on the same edge
  a_r5_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wrGrant |-> busyIn);
  // R4: a grant needs the latch set beforehand
  a_r4_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wrGrant |-> $past(welIn));
  // R6: a deny from idle leaves busy clear
  a_r6_deny_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wrDeny && !$past(busyIn)) |-> !busyIn);
  // R6: never both pulses
  a_r6_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrGrant && wrDeny));
endmodule

// File: rtl/srp_top.sv
module srp_top
  import srp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [2:0] INIT_PROT = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrenCmd,
  input  logic              wrdiCmd,
  input  logic              arrayWrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              statusWrReq,
  input  logic [7:0]        statusWrData,
  input  logic              cycleEnd,
  input  logic              writeProtectN,
  output logic [7:0]        statusOut,
  output logic              wrGrant,
  output logic              wrDeny
);
  strobe_t stb;
  logic    welQ, busyQ, wpenQ, addrProtected;

  srp_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrenCmd(wrenCmd), .wrdiCmd(wrdiCmd),
    .arrayWrReq(arrayWrReq), .statusWrReq(statusWrReq), .cycleEnd(cycleEnd),
    .writeProtectN(writeProtectN), .welIn(welQ), .busyIn(busyQ), .wpenIn(wpenQ),
    .addrProtected(addrProtected), .stb(stb), .wrGrant(wrGrant), .wrDeny(wrDeny)
  );

  srp_datapath #(.ADDR_W(ADDR_W), .INIT_PROT(INIT_PROT)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(statusWrData), .addr(wrAddr),
    .welQ(welQ), .busyQ(busyQ), .wpenQ(wpenQ), .addrProtected(addrProtected),
    .statusOut(statusOut)
  );
endmodule

// File: tb/srp_top_tb_top.sv
module srp_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrenCmd = 0, wrdiCmd = 0, arrayWrReq = 0, statusWrReq = 0, cycleEnd = 0;
  logic writeProtectN = 1'b1;
  logic [12:0] wrAddr = '0;
  logic [7:0]  statusWrData = '0;
  logic [7:0]  statusOut;
  logic        wrGrant, wrDeny;

  always #2.5 clk = ~clk;

  srp_top dut_i (
    .clk(clk), .rst_n(rst_n), .wrenCmd(wrenCmd), .wrdiCmd(wrdiCmd),
    .arrayWrReq(arrayWrReq), .wrAddr(wrAddr), .statusWrReq(statusWrReq),
    .statusWrData(statusWrData), .cycleEnd(cycleEnd), .writeProtectN(writeProtectN),
    .statusOut(statusOut), .wrGrant(wrGrant), .wrDeny(wrDeny)
  );

  typedef struct {
    string      tag;
    logic       g;
    logic       d;
    logic [7:0] s;
  } exp_t;

  exp_t expQ[$];
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  // reference state
  bit       mWel = 0, mBusy = 0, mWpen = 0;
  bit [1:0] mBp = 2'b00;

  function automatic logic [7:0] mStatus();
    return mBusy ? 8'hFF : {mWpen, 3'b000, mBp, mWel, 1'b0};
  endfunction

  function automatic bit guarded(logic [12:0] a);
    case (mBp)
      2'b00:   return 0;
      2'b01:   return a >= 13'h1800;
      2'b10:   return a >= 13'h1000;
      default: return 1;
    endcase
  endfunction

  task automatic op(string tag, bit en, bit di, bit ra, logic [12:0] a,
                    bit rs, logic [7:0] dat, bit ce);
    bit ok;
    exp_t e;
    @(negedge clk);
    wrenCmd = en; wrdiCmd = di; arrayWrReq = ra; wrAddr = a;
    statusWrReq = rs; statusWrData = dat; cycleEnd = ce;
    ok = !(ra && rs) && mWel && !mBusy &&
         ((ra && !guarded(a)) || (rs && !(mWpen && !writeProtectN)));
    if (ce && mBusy) begin mBusy = 0; mWel = 0; end
    else if (!mBusy) begin
      if (di) mWel = 0;
      else if (en) mWel = 1;
    end
    if (ok) begin
      mBusy = 1;
      if (rs) begin mWpen = dat[7]; mBp = dat[3:2]; end
    end
    e.tag = tag; e.g = ok; e.d = (ra || rs) && !ok; e.s = mStatus();
    expQ.push_back(e);
    @(negedge clk);
    wrenCmd = 0; wrdiCmd = 0; arrayWrReq = 0; statusWrReq = 0; cycleEnd = 0;
  endtask

  task automatic idle(string tag);       op(tag, 0, 0, 0, '0, 0, '0, 0); endtask
  task automatic wren(string tag);       op(tag, 1, 0, 0, '0, 0, '0, 0); endtask
  task automatic wrdi(string tag);       op(tag, 0, 1, 0, '0, 0, '0, 0); endtask
  task automatic arr(string tag, logic [12:0] a); op(tag, 0, 0, 1, a, 0, '0, 0); endtask
  task automatic sts(string tag, logic [7:0] d);  op(tag, 0, 0, 0, '0, 1, d, 0); endtask
  task automatic fin(string tag);        op(tag, 0, 0, 0, '0, 0, '0, 1); endtask

  // monitor: compare outputs one step after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (wrGrant !== e.g || wrDeny !== e.d || statusOut !== e.s) begin
        errors++;
        $display("FAIL %s: grant=%0b deny=%0b status=%02h expected grant=%0b deny=%0b status=%02h",
                 e.tag, wrGrant, wrDeny, statusOut, e.g, e.d, e.s);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset status");
    arr("R4 array write without latch", 13'h0010);
    sts("R4 status write without latch", 8'h0C);
    wren("R3 set latch");
    wrdi("R3 clear latch");
    op("R3 clear wins over set", 1, 1, 0, '0, 0, '0, 0);
    wren("R3 set again");
    arr("R5 grant array write", 13'h1FFF);
    idle("R5 busy reads all ones");
    wren("R7 set ignored while busy");
    arr("R7 request while busy", 13'h0000);
    fin("R3 end clears latch and busy");
    idle("R7 latch stayed clear");
    wren("R2 latch for status write");
    op("R10 both requests denied", 0, 0, 1, 13'h0001, 1, 8'h04, 0);
    sts("R2 status write BP=01 with junk bits", 8'h74);
    fin("R2 end of status cycle");
    wren("R8 latch");
    arr("R8 BP01 lowest guarded", 13'h1800);
    arr("R8 BP01 last open", 13'h17FF);
    fin("R8 end");
    wren("R2 latch");
    sts("R2 set BP=10", 8'h08);
    fin("R2 end");
    wren("R8 latch");
    arr("R8 BP10 lowest guarded", 13'h1000);
    arr("R8 BP10 last open", 13'h0FFF);
    fin("R8 end");
    wren("R2 latch");
    sts("R9 set wpen BP=11 pin high", 8'h8C);
    fin("R9 end");
    wren("R8 latch");
    arr("R8 BP11 address zero", 13'h0000);
    arr("R8 BP11 mid", 13'h0A55);
    writeProtectN = 1'b0;
    sts("R9 status write with pin low", 8'h00);
    idle("R6 deny left status");
    writeProtectN = 1'b1;
    sts("R9 status write pin high", 8'h00);
    fin("R9 end");
    wren("R9 latch");
    writeProtectN = 1'b0;
    arr("R9 array write ignores pin", 13'h1FFF);
    fin("R9 end");
    writeProtectN = 1'b1;
    fin("R5 end when idle has no effect");
    idle("R6 pulses gone");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule